// File: doc/BRIEF.md
# Thermal Line Protection Controller

This block keeps the thermal protection state for a group of power-feed line switches and works out the drive each switch actually receives. Two temperature flags come in from an external sensor: a lower-threshold flag that trips only those lines currently reporting a current overload, and an upper-threshold flag that trips every line and raises a global shutdown indication. A tripped line stays latched off until software has withdrawn its enable and the upper-threshold condition has gone away.

Each switch follows its enable through a programmable turn-on and turn-off delay counted in clock cycles. This models the finite switching time of the output stage. A thermal trip bypasses the turn-off delay and removes the drive at once. The effective-enable output, used downstream to gate the overload interrupt, follows the real switch state.

Top module: `thermal_line_guard`

## Requirements
- R1: After reset, every protection status bit reads 1 (line operational), the shutdown flag reads 0 and every switch reads off.
- R2: On a clock edge where the lower-threshold flag is 1, every line whose overload bit is 1 has its protection status bit cleared to 0. Lines with overload bit 0 are not affected.
- R3: A protection status bit that reads 0 stays 0 while that line's enable is 1, even after the overload and both temperature flags have gone to 0.
- R4: One cycle after the upper-threshold flag is sampled as 1, all protection status bits read 0 and the shutdown flag reads 1.
- R5: The shutdown flag stays 1 while the upper-threshold flag is held. It reads 0 one cycle after that flag is sampled as 0.
- R6: A protection status bit returns to 1 one cycle after that line's enable is 0 with the upper-threshold flag 0. It stays 0 while the upper-threshold flag is 1, even if the enable is 0.
- R7: With its status bit at 1, a switch turns on exactly ON_DLY clock edges after its enable is sampled as 1, and not earlier.
- R8: A switch that is on turns off exactly OFF_DLY clock edges after its enable is sampled as 0, and not earlier.
- R9: An enable pulse shorter than ON_DLY cycles leaves the switch off. A disable gap shorter than OFF_DLY cycles leaves it on.
- R10: When a line's protection status bit falls to 0, its switch reads off in the same cycle, with no turn-off delay. A switch is never on while its status bit is 0.
- R11: The effective-enable vector always equals the switch-state vector.
- R12: Overload bits have no effect on the protection state while the lower-threshold flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_en_i | input | N_LINES | Software line enable, one bit per line |
| ovl_i | input | N_LINES | Live current-overload indication per line |
| hot_lo_i | input | 1 | Lower temperature threshold reached |
| hot_hi_i | input | 1 | Upper temperature threshold reached |
| tor_o | output | N_LINES | Protection status per line, 1 = operational, 0 = forced off |
| shutdown_o | output | 1 | Global over-temperature shutdown flag |
| sw_state_o | output | N_LINES | Actual switch drive per line, 1 = on |
| eff_en_o | output | N_LINES | Effective enable for interrupt gating |

## Verification
A wrong latch bit appears at tor_o one cycle after the offending input edge. Because the switch drive is gated by that bit, it also shows at sw_state_o in that same cycle. A wrong delay counter appears only as a switch edge that comes one or more cycles early or late, or never comes, so the bench samples both just before and exactly at the expected edge. A stuck shutdown flag shows one cycle after the upper-threshold flag changes.

// File: rtl/tlg_pkg.sv
package tlg_pkg;

  function automatic int unsigned tlg_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned tlg_cnt_w(input int unsigned on_d, input int unsigned off_d);
    int unsigned m;
    m = tlg_max(on_d, off_d);
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/tlg_trip_latch.sv
module tlg_trip_latch #(
  parameter int unsigned N_LINES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_en_i,
  input  logic [N_LINES-1:0] ovl_i,
  input  logic               hot_lo_i,
  input  logic               hot_hi_i,
  output logic [N_LINES-1:0] tor_o,
  output logic               shutdown_o
);

  logic [N_LINES-1:0] tor_q;
  logic               sd_q;

  for (genvar k = 0; k < N_LINES; k++) begin : g_bit
    logic trip, release_ok, tor_d;

    assign trip       = hot_hi_i | (hot_lo_i & ovl_i[k]);
    // release only once software withdrew the enable and upper flag is gone
    assign release_ok = ~line_en_i[k] & ~hot_hi_i;

    always_comb begin
      tor_d = tor_q[k];
      if (trip)                       tor_d = 1'b0;
      else if (!tor_q[k] && release_ok) tor_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tor_q[k] <= 1'b1;
      else         tor_q[k] <= tor_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sd_q <= 1'b0;
    else         sd_q <= hot_hi_i;
  end

  assign tor_o      = tor_q;
  assign shutdown_o = sd_q;

endmodule

// File: rtl/tlg_switch_timer.sv
module tlg_switch_timer #(
  parameter int unsigned ON_DLY  = 4,
  parameter int unsigned OFF_DLY = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic allow_i,
  output logic sw_o
);

  localparam int unsigned CW = tlg_pkg::tlg_cnt_w(ON_DLY, OFF_DLY);
  localparam logic [CW-1:0] ON_LIM  = CW'(ON_DLY - 1);
  localparam logic [CW-1:0] OFF_LIM = CW'(OFF_DLY - 1);

  logic          sw_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = req_i ? ON_LIM : OFF_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!allow_i) begin
      sw_q  <= 1'b0;
      cnt_q <= '0;
    end else if (req_i == sw_q) begin
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      sw_q  <= req_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // trip removes drive without waiting for the off delay
  assign sw_o = sw_q & allow_i;

endmodule

// File: rtl/thermal_line_guard.sv
module thermal_line_guard #(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ON_DLY  = 4,
  parameter int unsigned OFF_DLY = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_en_i,
  input  logic [N_LINES-1:0] ovl_i,
  input  logic               hot_lo_i,
  input  logic               hot_hi_i,
  output logic [N_LINES-1:0] tor_o,
  output logic               shutdown_o,
  output logic [N_LINES-1:0] sw_state_o,
  output logic [N_LINES-1:0] eff_en_o
);

  logic [N_LINES-1:0] tor_w;
  logic [N_LINES-1:0] sw_w;

  tlg_trip_latch #(.N_LINES(N_LINES)) i_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_en_i  (line_en_i),
    .ovl_i      (ovl_i),
    .hot_lo_i   (hot_lo_i),
    .hot_hi_i   (hot_hi_i),
    .tor_o      (tor_w),
    .shutdown_o (shutdown_o)
  );

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    tlg_switch_timer #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) i_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (line_en_i[k] & tor_w[k]),
      .allow_i (tor_w[k]),
      .sw_o    (sw_w[k])
    );
  end

  assign tor_o      = tor_w;
  assign sw_state_o = sw_w;
  assign eff_en_o   = sw_w;

endmodule

// File: rtl/tlg_checker.sv
module tlg_checker #(
  parameter int unsigned N_LINES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] line_en_i,
  input logic [N_LINES-1:0] ovl_i,
  input logic               hot_lo_i,
  input logic               hot_hi_i,
  input logic [N_LINES-1:0] tor_o,
  input logic               shutdown_o,
  input logic [N_LINES-1:0] sw_state_o,
  input logic [N_LINES-1:0] eff_en_o
);

  assert_hi_trips_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_hi_i |=> (tor_o == '0) && shutdown_o);

  assert_sd_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hot_hi_i |=> !shutdown_o);

  assert_lo_trips_ovl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_lo_i |=> ((tor_o & $past(ovl_i)) == '0));

  assert_release_rule_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((tor_o & ~$past(tor_o)) & $past(line_en_i)) == '0));

  assert_no_release_hot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hot_hi_i |=> ((tor_o & ~$past(tor_o)) == '0));

  assert_sw_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_state_o & ~tor_o) == '0);

  assert_on_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((sw_state_o & ~$past(sw_state_o)) & ~$past(line_en_i)) == '0));

  assert_eff_eq_sw_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_en_o == sw_state_o);

endmodule

bind thermal_line_guard tlg_checker #(.N_LINES(N_LINES)) i_tlg_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_en_i  (line_en_i),
  .ovl_i      (ovl_i),
  .hot_lo_i   (hot_lo_i),
  .hot_hi_i   (hot_hi_i),
  .tor_o      (tor_o),
  .shutdown_o (shutdown_o),
  .sw_state_o (sw_state_o),
  .eff_en_o   (eff_en_o)
);

// File: tb/test_thermal_line_guard.sv
module test_thermal_line_guard;

  localparam int unsigned N  = 4;
  localparam int unsigned ON  = 4;
  localparam int unsigned OFF = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] line_en = '0;
  logic [N-1:0] ovl = '0;
  logic         hot_lo = 1'b0;
  logic         hot_hi = 1'b0;
  logic [N-1:0] tor, sw, eff;
  logic         sd;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  thermal_line_guard #(.N_LINES(N), .ON_DLY(ON), .OFF_DLY(OFF)) i_thermal_line_guard (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .line_en_i  (line_en),
    .ovl_i      (ovl),
    .hot_lo_i   (hot_lo),
    .hot_hi_i   (hot_hi),
    .tor_o      (tor),
    .shutdown_o (sd),
    .sw_state_o (sw),
    .eff_en_o   (eff)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1", "tor", 8'(tor), 8'hF);
    chk("R1", "shutdown", 8'(sd), 8'h0);
    chk("R1", "switch", 8'(sw), 8'h0);
  endtask

  task automatic t_on_delay;
    line_en = 4'b0011;
    step(ON - 1);
    chk("R7", "switch before on delay", 8'(sw), 8'h0);
    step(1);
    chk("R7", "switch at on delay", 8'(sw), 8'h3);
    chk("R11", "eff_en", 8'(eff), 8'h3);
  endtask

  task automatic t_off_delay;
    line_en = 4'b0001;
    step(OFF - 1);
    chk("R8", "switch before off delay", 8'(sw), 8'h3);
    step(1);
    chk("R8", "switch at off delay", 8'(sw), 8'h1);
    chk("R11", "eff_en", 8'(eff), 8'h1);
  endtask

  task automatic t_short_pulse;
    line_en = 4'b0101;
    step(ON - 2);
    line_en = 4'b0001;
    step(OFF);
    chk("R9", "short enable pulse", 8'(sw), 8'h1);
    line_en = 4'b0000;
    step(OFF - 2);
    line_en = 4'b0001;
    step(OFF);
    chk("R9", "short disable gap", 8'(sw), 8'h1);
  endtask

  task automatic t_ovl_ignored;
    ovl = 4'b1111;
    step(3);
    chk("R12", "tor with overload only", 8'(tor), 8'hF);
    chk("R12", "switch with overload only", 8'(sw), 8'h1);
    ovl = '0;
  endtask

  task automatic t_selective;
    line_en = 4'b0011;
    step(ON + 1);
    chk("R7", "second line on", 8'(sw), 8'h3);
    ovl = 4'b0010;
    hot_lo = 1'b1;
    step(1);
    chk("R2", "selective trip", 8'(tor), 8'hD);
    chk("R10", "tripped switch off at once", 8'(sw), 8'h1);
    hot_lo = 1'b0;
    ovl = '0;
    step(3);
    chk("R3", "latched while enabled", 8'(tor), 8'hD);
    chk("R3", "switch stays off", 8'(sw), 8'h1);
    line_en = 4'b0001;
    step(1);
    chk("R6", "release after disable", 8'(tor), 8'hF);
    chk("R6", "switch after release", 8'(sw), 8'h1);
  endtask

  task automatic t_global;
    line_en = 4'b0001;
    hot_hi = 1'b1;
    step(1);
    chk("R4", "all tripped", 8'(tor), 8'h0);
    chk("R4", "shutdown set", 8'(sd), 8'h1);
    chk("R10", "switch off at once", 8'(sw), 8'h0);
    line_en = 4'b0000;
    step(3);
    chk("R6", "no release while hot", 8'(tor), 8'h0);
    chk("R5", "shutdown held", 8'(sd), 8'h1);
    hot_hi = 1'b0;
    step(1);
    chk("R5", "shutdown cleared", 8'(sd), 8'h0);
    chk("R6", "release after cool", 8'(tor), 8'hF);
    chk("R11", "eff_en off", 8'(eff), 8'h0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_on_delay();
    t_off_delay();
    t_short_pulse();
    t_ovl_ignored();
    t_selective();
    t_global();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule